// File: doc/BRIEF.md
# Two-cache snooping invalidate coherence controller

This block keeps two private write-through caches coherent over one shared bus to a register-based main memory. Each cache is direct-mapped with single-word lines, and every line is either valid or invalid. Reads that hit are answered locally. Reads that miss fetch the word from memory over the bus and fill the line. Every write goes over the bus: memory is updated, the writer's own line takes the new value, and the other cache snoops the same transaction as an invalidate. If the other cache holds that address, it drops its copy, so its next read misses and fetches the fresh word.

Each processor port uses a request/acknowledge handshake. The processor holds `*_req_i` and its operands stable until `*_ack_o` pulses for one cycle, and it drops the request in the cycle that follows. A write is acknowledged only after its bus transaction, which is also the invalidate, has been granted and applied. The bus carries one transaction per cycle. When both caches want it in the same cycle, cache A is served first.

Top module: `snoop_inval_ctrl`

## Requirements
- R1: After reset, both acknowledges are low, every line in both caches is invalid, and memory word k holds the value k (zero-extended address). The first read of any address therefore misses.
- R2: A read whose address is held valid in the cache (index = addr[2:0], tag = addr[5:3]) acknowledges one cycle after the request is sampled and returns the cached word.
- R3: A read miss, when the bus is free, acknowledges two cycles after the request is sampled, returns the memory word and fills the line.
- R4: Every write takes the bus, writes memory, and leaves the writer's line valid with the new word. It is acknowledged two cycles after the request when uncontended, and the acknowledge is a one-cycle pulse.
- R5: A write invalidates a matching valid line in the other cache. That cache's next read of the address misses and returns the written value. For example, after A reads X, B reads X and A writes 1 to X, B reads 1.
- R6: An invalidate only removes a line whose index and tag both match the written address. A line at the same index with a different tag stays valid and keeps hitting.
- R7: At most one cache owns the bus per cycle, and A wins when both request. With simultaneous misses, A acknowledges after 2 cycles and B after 3.
- R8: Simultaneous writes to one address are ordered A then B in both caches and in memory. Afterwards, every read returns B's value, and A's copy is invalidated by B's write.
- R9: A fill into an index that holds another tag replaces that line, so the evicted address misses on its next read.
- R10: A read whose address matches the invalidate on the bus in the cycle it is sampled is treated as a miss, so it returns the written value and not the stale copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_req_i | input | 1 | Processor A request, held until acknowledge |
| a_we_i | input | 1 | Processor A write (1) or read (0) |
| a_addr_i | input | ADDR_W | Processor A word address |
| a_wdata_i | input | DATA_W | Processor A write data |
| a_ack_o | output | 1 | Processor A one-cycle completion pulse |
| a_rdata_o | output | DATA_W | Processor A read data, valid with acknowledge |
| b_req_i | input | 1 | Processor B request, held until acknowledge |
| b_we_i | input | 1 | Processor B write (1) or read (0) |
| b_addr_i | input | ADDR_W | Processor B word address |
| b_wdata_i | input | DATA_W | Processor B write data |
| b_ack_o | output | 1 | Processor B one-cycle completion pulse |
| b_rdata_o | output | DATA_W | Processor B read data, valid with acknowledge |

## Verification
The main function is exercised by sequences of reads and writes from each side. These sequences are built so that both the returned word and the acknowledge latency distinguish hits, fills, stale copies and evictions. Writes are aimed at the same index with a different tag to show that the invalidate compares the full address, and they are aimed at the exact address to show that the copy is dropped. Concurrent patterns include simultaneous misses, simultaneous writes to one word, and a read issued one cycle behind a remote write. These patterns separate fixed-priority ordering and same-cycle snoop conflicts from plain sequential coherence.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2
  } cache_st_e;
endpackage

// File: rtl/coh_arb.sv
module coh_arb #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest index wins
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt_o[i] = req_i[i] & ~taken;
      taken    = taken | req_i[i];
    end
  end

  a_r7_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r7_grant_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/coh_mem.sv
module coh_mem #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(i);
    end else if (bus_valid_i && bus_we_i) begin
      mem_q[bus_addr_i] <= bus_wdata_i;
    end
  end

  assign bus_rdata_o = mem_q[bus_addr_i];

  a_r4_mem_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && bus_we_i |=> mem_q[$past(bus_addr_i)] == $past(bus_wdata_i));
endmodule

// File: rtl/coh_cache.sv
module coh_cache
  import coh_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LINES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              gnt_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  cache_st_e         state_q;
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic              op_we_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;

  logic [IDX_W-1:0]  in_idx, snp_idx, op_idx;
  logic [TAG_W-1:0]  in_tag, snp_tag, op_tag;
  logic              snp_kill, hit, snp_match;
  logic [DATA_W-1:0] fill_data;

  assign in_idx  = addr_i[IDX_W-1:0];
  assign in_tag  = addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];
  assign op_idx  = op_addr_q[IDX_W-1:0];
  assign op_tag  = op_addr_q[ADDR_W-1:IDX_W];

  // a copy being invalidated this cycle must not serve a hit
  assign snp_kill  = snp_valid_i && (snp_addr_i == addr_i);
  assign hit       = valid_q[in_idx] && (tag_q[in_idx] == in_tag) && !snp_kill;
  assign snp_match = snp_valid_i && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
  assign fill_data = op_we_q ? op_wdata_q : bus_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      valid_q    <= '0;
      ack_q      <= 1'b0;
      rdata_q    <= '0;
      op_we_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      ack_q <= 1'b0;
      if (snp_match) valid_q[snp_idx] <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            op_we_q    <= we_i;
            op_addr_q  <= addr_i;
            op_wdata_q <= wdata_i;
            if (!we_i && hit) begin
              rdata_q <= data_q[in_idx];
              ack_q   <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_BUS;
            end
          end
        end
        ST_BUS: begin
          if (gnt_i) begin
            valid_q[op_idx] <= 1'b1;
            tag_q[op_idx]   <= op_tag;
            data_q[op_idx]  <= fill_data;
            rdata_q         <= fill_data;
            ack_q           <= 1'b1;
            state_q         <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o       = ack_q;
  assign rdata_o     = rdata_q;
  assign bus_req_o   = (state_q == ST_BUS);
  assign bus_we_o    = op_we_q;
  assign bus_addr_o  = op_addr_q;
  assign bus_wdata_o = op_wdata_q;

  a_r2_hit_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && req_i && !we_i && hit
      |=> ack_o && (rdata_o == $past(data_q[in_idx])));
  a_r3_fill_returns_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUS) && gnt_i && !op_we_q |=> ack_o && (rdata_o == $past(bus_rdata_i)));
  a_r4_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r4_write_waits_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUS) && !gnt_i |=> !ack_o);
  a_r5_snoop_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_match |=> !valid_q[$past(snp_idx)]);
endmodule

// File: rtl/snoop_inval_ctrl.sv
module snoop_inval_ctrl #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LINES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_req_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic              a_ack_o,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_req_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic              b_ack_o,
  output logic [DATA_W-1:0] b_rdata_o
);
  localparam int unsigned NC = 2;

  logic              p_req   [NC];
  logic              p_we    [NC];
  logic [ADDR_W-1:0] p_addr  [NC];
  logic [DATA_W-1:0] p_wdata [NC];
  logic              p_ack   [NC];
  logic [DATA_W-1:0] p_rdata [NC];

  logic [NC-1:0]     c_req, gnt;
  logic              c_we    [NC];
  logic [ADDR_W-1:0] c_addr  [NC];
  logic [DATA_W-1:0] c_wdata [NC];

  logic              bus_valid, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;

  assign p_req[0] = a_req_i;  assign p_we[0] = a_we_i;
  assign p_addr[0] = a_addr_i; assign p_wdata[0] = a_wdata_i;
  assign p_req[1] = b_req_i;  assign p_we[1] = b_we_i;
  assign p_addr[1] = b_addr_i; assign p_wdata[1] = b_wdata_i;
  assign a_ack_o = p_ack[0];   assign a_rdata_o = p_rdata[0];
  assign b_ack_o = p_ack[1];   assign b_rdata_o = p_rdata[1];

  for (genvar g = 0; g < NC; g++) begin : g_cache
    coh_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_cache (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (p_req[g]),
      .we_i        (p_we[g]),
      .addr_i      (p_addr[g]),
      .wdata_i     (p_wdata[g]),
      .ack_o       (p_ack[g]),
      .rdata_o     (p_rdata[g]),
      .bus_req_o   (c_req[g]),
      .bus_we_o    (c_we[g]),
      .bus_addr_o  (c_addr[g]),
      .bus_wdata_o (c_wdata[g]),
      .gnt_i       (gnt[g]),
      .bus_rdata_i (bus_rdata),
      .snp_valid_i (bus_valid && bus_we && !gnt[g]),
      .snp_addr_i  (bus_addr)
    );
  end

  coh_arb #(.N(NC)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (c_req),
    .gnt_o  (gnt)
  );

  always_comb begin
    bus_valid = |gnt;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    for (int i = 0; i < NC; i++) begin
      if (gnt[i]) begin
        bus_we    = c_we[i];
        bus_addr  = c_addr[i];
        bus_wdata = c_wdata[i];
      end
    end
  end

  coh_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata)
  );

  a_r7_a_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_req[0] |-> !gnt[1]);
  a_r4_one_cycle_acks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_ack_o |=> !a_ack_o);
endmodule

// File: tb/snoop_inval_ctrl_tb.sv
module snoop_inval_ctrl_tb;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req [2];
  logic          we  [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wdata [2];
  logic          ack [2];
  logic [DW-1:0] rdata [2];

  int checks = 0;
  int errors = 0;

  snoop_inval_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_req_i(req[0]), .a_we_i(we[0]), .a_addr_i(addr[0]), .a_wdata_i(wdata[0]),
    .a_ack_o(ack[0]), .a_rdata_o(rdata[0]),
    .b_req_i(req[1]), .b_we_i(we[1]), .b_addr_i(addr[1]), .b_wdata_i(wdata[1]),
    .b_ack_o(ack[1]), .b_rdata_o(rdata[1])
  );

  typedef struct packed {
    logic          port;
    logic          wr;
    logic [AW-1:0] ad;
    logic [DW-1:0] wd;
    logic [DW-1:0] exp;
    logic [3:0]    lat;
    logic [3:0]    rq;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{1'b0, 1'b0, 6'h05, 16'h0000, 16'h0005, 4'd2, 4'd3},  // R3 A miss
    '{1'b0, 1'b0, 6'h05, 16'h0000, 16'h0005, 4'd1, 4'd2},  // R2 A hit
    '{1'b1, 1'b0, 6'h05, 16'h0000, 16'h0005, 4'd2, 4'd3},  // R3 B miss
    '{1'b1, 1'b0, 6'h05, 16'h0000, 16'h0005, 4'd1, 4'd2},  // R2 B hit
    '{1'b0, 1'b1, 6'h05, 16'h0001, 16'h0001, 4'd2, 4'd4},  // R4 A writes 1
    '{1'b0, 1'b0, 6'h05, 16'h0000, 16'h0001, 4'd1, 4'd4},  // R4 writer line updated
    '{1'b1, 1'b0, 6'h05, 16'h0000, 16'h0001, 4'd2, 4'd5},  // R5 B stale copy gone
    '{1'b1, 1'b0, 6'h0D, 16'h0000, 16'h000D, 4'd2, 4'd9},  // R9 same index other tag
    '{1'b1, 1'b0, 6'h05, 16'h0000, 16'h0001, 4'd2, 4'd9},  // R9 evicted, memory holds 1
    '{1'b1, 1'b0, 6'h02, 16'h0000, 16'h0002, 4'd2, 4'd3},  // R3
    '{1'b0, 1'b1, 6'h0A, 16'h1234, 16'h1234, 4'd2, 4'd4},  // R4 same index, tag differs
    '{1'b1, 1'b0, 6'h02, 16'h0000, 16'h0002, 4'd1, 4'd6},  // R6 B line kept
    '{1'b1, 1'b0, 6'h0A, 16'h0000, 16'h1234, 4'd2, 4'd5},  // R5 B fetches new word
    '{1'b0, 1'b0, 6'h0A, 16'h0000, 16'h1234, 4'd1, 4'd2},  // R2 A hit
    '{1'b1, 1'b1, 6'h0A, 16'hBEEF, 16'hBEEF, 4'd2, 4'd4},  // R4 B writes
    '{1'b0, 1'b0, 6'h0A, 16'h0000, 16'hBEEF, 4'd2, 4'd5}   // R5 A invalidated
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, got, exp);
    end
  endtask

  task automatic op(input int p, input bit w, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, output int lat, output logic [DW-1:0] q);
    @(negedge clk);
    req[p] = 1'b1; we[p] = w; addr[p] = a; wdata[p] = d;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!ack[p] && lat < 40);
    q = rdata[p];
    req[p] = 1'b0;
  endtask

  task automatic run(input int p, input bit w, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input int elat, input logic [DW-1:0] eq,
                     input string rq);
    int lat;
    logic [DW-1:0] q;
    op(p, w, a, d, lat, q);
    chk(lat == elat, rq, "latency", lat, elat);
    if (!w) chk(q == eq, rq, "data", int'(q), int'(eq));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int la, lb;
    logic [DW-1:0] qa, qb;
    for (int i = 0; i < 2; i++) begin
      req[i] = 1'b0; we[i] = 1'b0; addr[i] = '0; wdata[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!ack[0] && !ack[1], "R1", "acks in reset", {ack[0], ack[1]}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack[0] && !ack[1], "R1", "acks after reset", {ack[0], ack[1]}, 0);
    run(0, 1'b0, 6'h3F, '0, 2, 16'h003F, "R1");

    for (int i = 0; i < 16; i++) begin
      run(int'(VEC[i].port), VEC[i].wr, VEC[i].ad, VEC[i].wd, int'(VEC[i].lat),
          VEC[i].exp, $sformatf("R%0d", VEC[i].rq));
    end

    // R7 simultaneous misses: A first
    fork
      op(0, 1'b0, 6'h21, '0, la, qa);
      op(1, 1'b0, 6'h33, '0, lb, qb);
    join
    chk(la == 2, "R7", "A latency", la, 2);
    chk(lb == 3, "R7", "B latency", lb, 3);
    chk(qa == 16'h0021 && qb == 16'h0033, "R7", "data", int'(qb), 16'h0033);

    // R8 simultaneous writes to one word: B lands last
    fork
      op(0, 1'b1, 6'h30, 16'h1111, la, qa);
      op(1, 1'b1, 6'h30, 16'h2222, lb, qb);
    join
    chk(la == 2 && lb == 3, "R8", "write order latencies", la * 16 + lb, 16'h23);
    run(0, 1'b0, 6'h30, '0, 2, 16'h2222, "R8");
    run(1, 1'b0, 6'h30, '0, 1, 16'h2222, "R8");

    // R10 read sampled while invalidate for it is on the bus
    run(1, 1'b0, 6'h17, '0, 2, 16'h0017, "R10");
    fork
      op(0, 1'b1, 6'h17, 16'h7777, la, qa);
      begin
        @(negedge clk);
        op(1, 1'b0, 6'h17, '0, lb, qb);
      end
    join
    chk(lb == 2, "R10", "read latency", lb, 2);
    chk(qb == 16'h7777, "R10", "read data", int'(qb), 16'h7777);

    // R1 mid-run reset restores memory and empties lines
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run(0, 1'b0, 6'h05, '0, 2, 16'h0005, "R1");
    run(1, 1'b0, 6'h17, '0, 2, 16'h0017, "R1");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule